// File: doc/BRIEF.md
# Cartridge Flash and SRAM Bank Mapper

This block is the address-decode and bank-switching core of a plug-in expansion cartridge for an 8-bit home computer. The cartridge carries a 4 MB parallel flash and a 32 kB SRAM. The host board supplies one select strobe for each expansion window, the address bus and a read/write line. The mapper turns these into the flash upper address lines, the SRAM quarter-select lines and the chip enables and write enable. The low address lines run straight from the host to both memories.

Software programs the mapper through two byte registers in the I/O window. The page register picks one 8 kB flash page. A packed setup byte picks the rest: an extra flash address bit, a master RAM switch, where the first 8 kB of SRAM appears, flash or SRAM in the top window, write protection of that window, and a lock bit. The lock bit hides both registers until the next hardware reset. After reset, flash page 0 is readable in the top window, so boot code runs straight away.

SRAM is split into four 8 kB quarters. Quarter 0 serves the low 3 kB gap or the $2000 window. Quarter 1 serves the $4000 window, quarter 2 serves $6000, and quarter 3 serves the top $A000 window when SRAM is placed there.

Top module: `cartMapper`

## Requirements
- R1: After reset the page register reads $00 and the setup register reads $40. A read strobe in the top window then asserts flashCe with flashAddrHi = 0.
- R2: A write to I/O address $9800 loads the page register. The register reads back at the same address, and its value drives flashAddrHi[7:0].
- R3: Setup bit 0 drives flashAddrHi[8], which is flash line A21.
- R4: Setup bits 2 and 1 ignore writes and read back as 0. Every other bit of $9801 reads back as written.
- R5: With setup bit 5 set, an access to the top window selects SRAM quarter 3 (sramAddrHi = 3) and never flash. With bit 5 clear, only reads in the top window assert flashCe. Writes there assert nothing.
- R6: sramWe is asserted only on a write to a window that is mapped to SRAM. It is never asserted in the top window while setup bit 6 is set.
- R7: Setup bit 3 is the master RAM switch for quarter 0. When it is set, bit 4 = 0 maps quarter 0 to the low gap and bit 4 = 1 maps it to the $2000 window. When it is clear, neither of these windows selects SRAM.
- R8: The $4000 and $6000 windows always select SRAM quarters 1 and 2, for reads and writes, whatever the setup bits are.
- R9: Once setup bit 7 has been written as 1, later register writes change nothing and register reads do not drive the data bus. Only a hardware reset clears this lock.
- R10: hostDataOe is high only on an unlocked read of $9800 or $9801. Other addresses inside the I/O window are not driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Active-low hardware reset |
| hostAddr | input | 16 | Host address bus |
| hostRnW | input | 1 | 1 = read, 0 = write |
| hostDataIn | input | 8 | Host write data |
| gapSel | input | 1 | Low 3 kB RAM gap strobe |
| blk1Sel | input | 1 | $2000 window strobe |
| blk2Sel | input | 1 | $4000 window strobe |
| blk3Sel | input | 1 | $6000 window strobe |
| blk5Sel | input | 1 | $A000 window strobe |
| ioSel | input | 1 | I/O window strobe holding the registers |
| hostDataOut | output | 8 | Register read data |
| hostDataOe | output | 1 | Drive enable for hostDataOut |
| flashAddrHi | output | 9 | Flash A21..A13 |
| flashCe | output | 1 | Flash chip enable (reads) |
| sramAddrHi | output | 2 | SRAM A14..A13 quarter select |
| sramCe | output | 1 | SRAM chip enable |
| sramWe | output | 1 | SRAM write enable |

## Verification
The bench builds the block with its default 8-bit page register and a 2-bit SRAM quarter select. This brings every page value and all 128 unlocked setup values within reach of an exhaustive sweep. For each setup value it reads the register back and walks every window strobe in both directions. It compares the enables, the quarter and the flash page against values worked out from the bit meanings. Separate passes cover the lock, the unused I/O offsets and the return to defaults after a second reset.

// File: rtl/cartMapPkg.sv
package cartMapPkg;
  typedef enum logic [2:0] {
    WIN_NONE, WIN_GAP, WIN_BLK1, WIN_BLK2, WIN_BLK3, WIN_BLK5
  } winT;

  // Register strobes from control to the register datapath
  typedef struct packed {
    logic bankLoad;
    logic cfgLoad;
    logic bankRead;
    logic cfgRead;
  } regStrobeT;

  // Memory access descriptor from control to the routing datapath
  typedef struct packed {
    logic isWrite;
    winT  win;
  } accessT;

  localparam int CFG_A21   = 0;
  localparam int CFG_RAMON = 3;
  localparam int CFG_BLK1  = 4;
  localparam int CFG_B5RAM = 5;
  localparam int CFG_WP    = 6;
  localparam int CFG_LOCK  = 7;

  localparam logic [7:0] CFG_RESET = 8'h40;
  localparam logic [7:0] CFG_KEEP  = 8'hF9;  // bits 2:1 are never stored
endpackage

// File: rtl/mapCtrl.sv
module mapCtrl
  import cartMapPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h9800
) (
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRnW,
  input  logic              gapSel,
  input  logic              blk1Sel,
  input  logic              blk2Sel,
  input  logic              blk3Sel,
  input  logic              blk5Sel,
  input  logic              ioSel,
  input  logic              regLocked,
  output regStrobeT         regStb,
  output accessT            access
);
  localparam logic [ADDR_W-1:0] CFG_ADDR = REG_BASE + ADDR_W'(1);

  logic bankHit, cfgHit, open;

  always_comb begin
    open    = ioSel && !regLocked;
    bankHit = open && (hostAddr == REG_BASE);
    cfgHit  = open && (hostAddr == CFG_ADDR);

    regStb.bankLoad = bankHit && !hostRnW;
    regStb.cfgLoad  = cfgHit  && !hostRnW;
    regStb.bankRead = bankHit && hostRnW;
    regStb.cfgRead  = cfgHit  && hostRnW;

    access.isWrite = !hostRnW;
    // fixed priority if the board ever raises several strobes
    if (gapSel)       access.win = WIN_GAP;
    else if (blk1Sel) access.win = WIN_BLK1;
    else if (blk2Sel) access.win = WIN_BLK2;
    else if (blk3Sel) access.win = WIN_BLK3;
    else if (blk5Sel) access.win = WIN_BLK5;
    else              access.win = WIN_NONE;
  end
endmodule

// File: rtl/mapRegs.sv
module mapRegs
  import cartMapPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobeT         regStb,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [BANK_W-1:0] bankQ,
  output logic [DATA_W-1:0] cfgQ,
  output logic              regLocked,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ <= '0;
      cfgQ  <= CFG_RESET;
    end else begin
      if (regStb.bankLoad) bankQ <= hostDataIn[BANK_W-1:0];
      if (regStb.cfgLoad)  cfgQ  <= hostDataIn & CFG_KEEP;
    end
  end

  always_comb begin
    regLocked   = cfgQ[CFG_LOCK];
    hostDataOe  = regStb.bankRead || regStb.cfgRead;
    hostDataOut = '0;
    if (regStb.bankRead)     hostDataOut = DATA_W'(bankQ);
    else if (regStb.cfgRead) hostDataOut = cfgQ;
  end

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    regLocked |=> regLocked);
  assert_locked_no_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    regLocked |-> !(regStb.bankLoad || regStb.cfgLoad));
  assert_bank_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    !regStb.bankLoad |=> $stable(bankQ));
  assert_single_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regStb.bankRead, regStb.cfgRead}));
endmodule

// File: rtl/mapRoute.sv
module mapRoute
  import cartMapPkg::*;
#(
  parameter int BANK_W     = 8,
  parameter int SRAM_SEL_W = 2,
  localparam int FLASH_HI_W = BANK_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  accessT                access,
  input  logic [BANK_W-1:0]     bankQ,
  input  logic                  a21,
  input  logic                  ramOn,
  input  logic                  blk1Mode,
  input  logic                  b5Ram,
  input  logic                  writeProt,
  output logic [FLASH_HI_W-1:0] flashAddrHi,
  output logic                  flashCe,
  output logic [SRAM_SEL_W-1:0] sramAddrHi,
  output logic                  sramCe,
  output logic                  sramWe
);
  logic ramHit, weAllowed;

  always_comb begin
    flashAddrHi = {a21, bankQ};
    flashCe     = 1'b0;
    ramHit      = 1'b0;
    weAllowed   = 1'b1;
    sramAddrHi  = '0;
    unique case (access.win)
      WIN_GAP:  ramHit = ramOn && !blk1Mode;
      WIN_BLK1: ramHit = ramOn && blk1Mode;
      WIN_BLK2: begin ramHit = 1'b1; sramAddrHi = SRAM_SEL_W'(1); end
      WIN_BLK3: begin ramHit = 1'b1; sramAddrHi = SRAM_SEL_W'(2); end
      WIN_BLK5: begin
        sramAddrHi = SRAM_SEL_W'(3);
        ramHit     = b5Ram;
        weAllowed  = !writeProt;
        flashCe    = !b5Ram && !access.isWrite;
      end
      default: ;
    endcase
    sramCe = ramHit;
    sramWe = ramHit && access.isWrite && weAllowed;
  end

  assert_one_device_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flashCe, sramCe}));
  assert_we_needs_ce_R6: assert property (@(posedge clk) disable iff (!rstN)
    sramWe |-> (sramCe && access.isWrite));
  assert_top_protect_R6: assert property (@(posedge clk) disable iff (!rstN)
    (access.win == WIN_BLK5 && writeProt) |-> !sramWe);
  assert_mid_always_ram_R8: assert property (@(posedge clk) disable iff (!rstN)
    (access.win == WIN_BLK2 || access.win == WIN_BLK3) |-> sramCe);
  assert_flash_read_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    flashCe |-> (!access.isWrite && access.win == WIN_BLK5));
endmodule

// File: rtl/cartMapper.sv
module cartMapper
  import cartMapPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 8,
  parameter int SRAM_SEL_W = 2,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h9800,
  localparam int FLASH_HI_W = BANK_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     hostAddr,
  input  logic                  hostRnW,
  input  logic [DATA_W-1:0]     hostDataIn,
  input  logic                  gapSel,
  input  logic                  blk1Sel,
  input  logic                  blk2Sel,
  input  logic                  blk3Sel,
  input  logic                  blk5Sel,
  input  logic                  ioSel,
  output logic [DATA_W-1:0]     hostDataOut,
  output logic                  hostDataOe,
  output logic [FLASH_HI_W-1:0] flashAddrHi,
  output logic                  flashCe,
  output logic [SRAM_SEL_W-1:0] sramAddrHi,
  output logic                  sramCe,
  output logic                  sramWe
);
  regStrobeT         regStb;
  accessT            access;
  logic [BANK_W-1:0] bankQ;
  logic [DATA_W-1:0] cfgQ;
  logic              regLocked;

  mapCtrl #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE)) ctrl (
    .hostAddr(hostAddr), .hostRnW(hostRnW), .gapSel(gapSel),
    .blk1Sel(blk1Sel), .blk2Sel(blk2Sel), .blk3Sel(blk3Sel),
    .blk5Sel(blk5Sel), .ioSel(ioSel), .regLocked(regLocked),
    .regStb(regStb), .access(access)
  );

  mapRegs #(.DATA_W(DATA_W), .BANK_W(BANK_W)) regs (
    .clk(clk), .rstN(rstN), .regStb(regStb), .hostDataIn(hostDataIn),
    .bankQ(bankQ), .cfgQ(cfgQ), .regLocked(regLocked),
    .hostDataOut(hostDataOut), .hostDataOe(hostDataOe)
  );

  mapRoute #(.BANK_W(BANK_W), .SRAM_SEL_W(SRAM_SEL_W)) route (
    .clk(clk), .rstN(rstN), .access(access), .bankQ(bankQ),
    .a21(cfgQ[CFG_A21]), .ramOn(cfgQ[CFG_RAMON]), .blk1Mode(cfgQ[CFG_BLK1]),
    .b5Ram(cfgQ[CFG_B5RAM]), .writeProt(cfgQ[CFG_WP]),
    .flashAddrHi(flashAddrHi), .flashCe(flashCe), .sramAddrHi(sramAddrHi),
    .sramCe(sramCe), .sramWe(sramWe)
  );
endmodule

// File: tb/cartMapper_test.sv
`timescale 1ns/1ps
module cartMapper_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] hostAddr = '0;
  logic hostRnW = 1'b1;
  logic [7:0] hostDataIn = '0;
  logic gapSel = 0, blk1Sel = 0, blk2Sel = 0, blk3Sel = 0, blk5Sel = 0, ioSel = 0;
  logic [7:0] hostDataOut;
  logic hostDataOe;
  logic [8:0] flashAddrHi;
  logic flashCe;
  logic [1:0] sramAddrHi;
  logic sramCe, sramWe;

  int total = 0, failed = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cartMapper uut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ioSel = 0; gapSel = 0; blk1Sel = 0; blk2Sel = 0; blk3Sel = 0; blk5Sel = 0;
    hostRnW = 1; hostAddr = '0;
  endtask

  task automatic regWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    idle(); ioSel = 1; hostAddr = a; hostRnW = 0; hostDataIn = d;
    @(negedge clk);
    idle();
  endtask

  task automatic regRead(input logic [15:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    idle(); ioSel = 1; hostAddr = a; hostRnW = 1;
    #1; d = hostDataOut; oe = hostDataOe;
    idle();
  endtask

  // drive window w (1 gap .. 5 top) with direction rnw, then sample
  task automatic access(input int w, input logic rnw);
    @(negedge clk);
    idle(); hostRnW = rnw;
    gapSel = (w == 1); blk1Sel = (w == 2); blk2Sel = (w == 3);
    blk3Sel = (w == 4); blk5Sel = (w == 5);
    #1;
  endtask

  task automatic checkWindows(input logic [7:0] c, input string req);
    for (int w = 1; w <= 5; w++) begin
      for (int r = 0; r < 2; r++) begin
        logic expRam, expFlash, expWe;
        int expQ;
        expRam = 0; expFlash = 0; expQ = 0;
        case (w)
          1: expRam = c[3] && !c[4];
          2: expRam = c[3] && c[4];
          3: begin expRam = 1; expQ = 1; end
          4: begin expRam = 1; expQ = 2; end
          default: begin expRam = c[5]; expQ = 3; expFlash = !c[5] && (r == 1); end
        endcase
        expWe = expRam && (r == 0) && !(w == 5 && c[6]);
        access(w, logic'(r));
        chk(req, $sformatf("sramCe c=%0h w=%0d r=%0d", c, w, r), sramCe, expRam);
        chk(req, $sformatf("sramWe c=%0h w=%0d r=%0d", c, w, r), sramWe, expWe);
        chk(req, $sformatf("flashCe c=%0h w=%0d r=%0d", c, w, r), flashCe, expFlash);
        if (expRam) chk(req, $sformatf("quarter c=%0h w=%0d", c, w), sramAddrHi, expQ);
      end
    end
    idle();
  endtask

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    regRead(16'h9800, d, oe); chk("R1", "bank reset", d, 8'h00);
    regRead(16'h9801, d, oe); chk("R1", "cfg reset", d, 8'h40); chk("R10", "oe on cfg read", oe, 1);
    access(5, 1); chk("R1", "boot flashCe", flashCe, 1); chk("R1", "boot page", flashAddrHi, 0);
    access(5, 0); chk("R6", "wp default no we", sramWe, 0);
    idle();

    // R2 sweep of every page value
    for (int b = 0; b < 256; b++) begin
      regWrite(16'h9800, 8'(b));
      regRead(16'h9800, d, oe); chk("R2", "bank readback", d, b);
      access(5, 1); chk("R2", "flash page", flashAddrHi, b);
    end
    idle();

    // R3..R8 sweep of every unlocked setup value
    for (int c = 0; c < 128; c++) begin
      regWrite(16'h9801, 8'(c));
      regRead(16'h9801, d, oe); chk("R4", "cfg readback pad", d, c & 8'hF9);
      access(5, 1); chk("R3", "A21", flashAddrHi[8], c & 1);
      checkWindows(8'(c), "R5_R6_R7_R8");
    end

    // R10 other I/O offsets stay undriven
    regRead(16'h9802, d, oe); chk("R10", "offset 2 oe", oe, 0);
    regRead(16'h97FF, d, oe); chk("R10", "below base oe", oe, 0);
    @(negedge clk); idle(); blk2Sel = 1; #1; chk("R10", "window read oe", hostDataOe, 0);
    idle();

    // R9 lock
    regWrite(16'h9800, 8'h5A);
    regWrite(16'h9801, 8'hA1);  // lock + top SRAM + A21
    regRead(16'h9801, d, oe); chk("R9", "locked read oe", oe, 0);
    regRead(16'h9800, d, oe); chk("R9", "locked bank oe", oe, 0);
    regWrite(16'h9800, 8'h33);
    regWrite(16'h9801, 8'h40);
    access(5, 1); chk("R9", "page held", flashAddrHi, 9'h15A);
    chk("R9", "top still sram", sramCe, 1);
    access(5, 0); chk("R9", "setup held no wp", sramWe, 1);
    idle();

    // R9 reset clears lock; R1 defaults again
    @(negedge clk); rstN = 0; @(negedge clk); rstN = 1;
    regRead(16'h9801, d, oe); chk("R9", "cfg after reset", d, 8'h40); chk("R9", "oe after reset", oe, 1);
    regRead(16'h9800, d, oe); chk("R1", "bank after reset", d, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule